// File: doc/BRIEF.md
# Single-Transfer PCI Bus Master Sequencer

This block lets a simple controller run one PCI bus access at a time. The controller presents an address, a write word, a four-bit bus command and four byte enables, then pulses a start input. The sequencer drives one address phase and one data phase on the shared bus. It then releases the bus and reports the word returned by the target, the C/BE# value seen when the transfer completed, a valid flag and a done flag. The controller polls the done flag and then checks the valid flag.

Bit 0 of the command selects the direction: 1 is a write, 0 is a read. Common codes are 0010/0011 for I/O read/write, 0110/0111 for memory read/write and 1010/1011 for configuration read/write. Every bus output is registered on the falling clock edge, so it is stable at the rising edge where the target samples it. TRDY#, AD and C/BE# coming back from the target are sampled on the rising edge. If no target answers, a watchdog counter ends the data phase after 2^TO_W sampling edges.

Top module: `pci_single_master`

## Requirements
- R1: After reset, all four bus output enables are low and done_o and valid_o are low.
- R2: On the falling edge after the rising edge that samples start_i high in idle, FRAME# is driven low, IRDY# is driven high, AD carries the address and C/BE# carries the command. All four enables are high.
- R3: One cycle later the data phase begins. FRAME# goes high while still driven, IRDY# is driven low, and C/BE# carries the byte enables. Only this one data phase is issued.
- R4: During the data phase, AD is driven with the write word when command bit 0 is 1, and its enable is low when command bit 0 is 0.
- R5: On a rising edge where IRDY# is low and TRDY# is low, AD is captured into rdata_o and C/BE# into cbe_stat_o, and valid_o is set.
- R6: If TRDY# stays high for 2^TO_W rising edges of the data phase, the access ends with valid_o low. done_o becomes visible 2^TO_W + 2 cycles after the start edge.
- R7: After the data phase there is exactly one cycle in which FRAME# and IRDY# are driven high and AD and C/BE# are released. After that cycle, all enables are low.
- R8: done_o rises when the sequencer returns to idle. For a target that asserts TRDY# on the same rising edge that first sees IRDY# low plus D cycles, done_o is visible 4 + D cycles after the start edge. A new accepted start clears both done_o and valid_o.
- R9: A start pulse while an access is in progress is ignored, and input changes after the start edge do not affect the running access.
- R10: Bus outputs do not change at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse; accepted only in idle |
| addr_i | input | 32 | Address for the address phase |
| wdata_i | input | 32 | Write word |
| cmd_i | input | 4 | Bus command; bit 0 = write |
| be_i | input | 4 | Active-low byte enables for the data phase |
| trdy_n_i | input | 1 | Target ready, active low |
| ad_i | input | 32 | AD bus as seen at the pins |
| cbe_i | input | 4 | C/BE# bus as seen at the pins |
| frame_n_o | output | 1 | FRAME# level |
| frame_oe_o | output | 1 | FRAME# driver enable |
| irdy_n_o | output | 1 | IRDY# level |
| irdy_oe_o | output | 1 | IRDY# driver enable |
| ad_o | output | 32 | AD drive value |
| ad_oe_o | output | 1 | AD driver enable |
| cbe_n_o | output | 4 | C/BE# drive value |
| cbe_oe_o | output | 1 | C/BE# driver enable |
| rdata_o | output | 32 | Word captured at completion |
| cbe_stat_o | output | 4 | C/BE# captured at completion |
| valid_o | output | 1 | Access completed with TRDY# |
| done_o | output | 1 | Access finished, sequencer idle |

## Verification
A sequencer stuck in the wrong state shows on the very next falling edge as a wrong FRAME#/IRDY# pair or as an AD enable of the wrong polarity. The bench compares these levels phase by phase, one cycle apart. A counter that is off by one moves the done_o edge of a timed-out access by a whole cycle, and a wrong capture condition leaves rdata_o or valid_o wrong once done_o rises. Target delays of zero and several cycles, plus a target that never answers, pin both ends of the wait window.

// File: rtl/pcim_pkg.sv
package pcim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_END  = 2'd3
  } pcim_state_e;

  localparam int unsigned WR_BIT = 0;
endpackage

// File: rtl/pcim_seq.sv
module pcim_seq
  import pcim_pkg::*;
#(
  parameter int unsigned TO_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go_i,
  input  logic        trdy_n_i,
  output pcim_state_e state_o,
  output logic        capture_o,
  output logic        finish_o
);
  localparam logic [TO_W-1:0] TO_MAX = {TO_W{1'b1}};

  pcim_state_e     state_q;
  logic [TO_W-1:0] wd_q;

  // TRDY# low forces the carry at once; otherwise the counter runs to its limit.
  logic carry;
  assign carry     = !trdy_n_i || (wd_q == TO_MAX);
  assign capture_o = (state_q == ST_WAIT) && !trdy_n_i;
  assign finish_o  = (state_q == ST_END);
  assign state_o   = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wd_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go_i) state_q <= ST_ADDR;
        ST_ADDR: begin
          state_q <= ST_WAIT;
          wd_q    <= '0;
        end
        ST_WAIT: begin
          if (carry) state_q <= ST_END;
          else       wd_q    <= wd_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcim_drive.sv
module pcim_drive
  import pcim_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned CBE_W = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pcim_state_e      state_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CBE_W-1:0] cmd_i,
  input  logic [CBE_W-1:0] be_i,
  output logic             frame_n_o,
  output logic             frame_oe_o,
  output logic             irdy_n_o,
  output logic             irdy_oe_o,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [CBE_W-1:0] cbe_n_o,
  output logic             cbe_oe_o
);
  // Falling-edge registers: every level is settled by the next rising edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      frame_n_o  <= 1'b1;
      frame_oe_o <= 1'b0;
      irdy_n_o   <= 1'b1;
      irdy_oe_o  <= 1'b0;
      ad_o       <= '0;
      ad_oe_o    <= 1'b0;
      cbe_n_o    <= '1;
      cbe_oe_o   <= 1'b0;
    end else begin
      frame_n_o  <= (state_i != ST_ADDR);
      irdy_n_o   <= (state_i != ST_WAIT);
      frame_oe_o <= (state_i != ST_IDLE);
      irdy_oe_o  <= (state_i != ST_IDLE);
      case (state_i)
        ST_ADDR: begin
          ad_o     <= addr_i;
          ad_oe_o  <= 1'b1;
          cbe_n_o  <= cmd_i;
          cbe_oe_o <= 1'b1;
        end
        ST_WAIT: begin
          ad_o     <= wdata_i;
          ad_oe_o  <= cmd_i[WR_BIT];
          cbe_n_o  <= be_i;
          cbe_oe_o <= 1'b1;
        end
        default: begin
          ad_oe_o  <= 1'b0;
          cbe_oe_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pcim_result.sv
module pcim_result #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned CBE_W = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic             capture_i,
  input  logic             finish_i,
  input  logic [BUS_W-1:0] ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [CBE_W-1:0] cbe_stat_o,
  output logic             valid_o,
  output logic             done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      cbe_stat_o <= '0;
      valid_o    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      if (go_i) begin
        valid_o <= 1'b0;
        done_o  <= 1'b0;
      end
      if (capture_i) begin
        rdata_o    <= ad_i;
        cbe_stat_o <= cbe_i;
        valid_o    <= 1'b1;
      end
      if (finish_i) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pci_single_master.sv
module pci_single_master
  import pcim_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned TO_W  = 8,
  localparam int unsigned CBE_W = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CBE_W-1:0] cmd_i,
  input  logic [CBE_W-1:0] be_i,
  input  logic             trdy_n_i,
  input  logic [BUS_W-1:0] ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic             frame_n_o,
  output logic             frame_oe_o,
  output logic             irdy_n_o,
  output logic             irdy_oe_o,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [CBE_W-1:0] cbe_n_o,
  output logic             cbe_oe_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic [CBE_W-1:0] cbe_stat_o,
  output logic             valid_o,
  output logic             done_o
);
  pcim_state_e      state;
  logic             capture, finish, go;
  logic [BUS_W-1:0] addr_q, wdata_q;
  logic [CBE_W-1:0] cmd_q, be_q;

  assign go = start_i && (state == ST_IDLE);

  // The request is held for the whole access.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      cmd_q   <= '0;
      be_q    <= '1;
    end else if (go) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      cmd_q   <= cmd_i;
      be_q    <= be_i;
    end
  end

  pcim_seq #(.TO_W(TO_W)) u_seq (
    .clk(clk), .rst(rst), .go_i(go), .trdy_n_i(trdy_n_i),
    .state_o(state), .capture_o(capture), .finish_o(finish)
  );

  pcim_drive #(.BUS_W(BUS_W), .CBE_W(CBE_W)) u_drive (
    .clk(clk), .rst(rst), .state_i(state),
    .addr_i(addr_q), .wdata_i(wdata_q), .cmd_i(cmd_q), .be_i(be_q),
    .frame_n_o(frame_n_o), .frame_oe_o(frame_oe_o),
    .irdy_n_o(irdy_n_o), .irdy_oe_o(irdy_oe_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .cbe_n_o(cbe_n_o), .cbe_oe_o(cbe_oe_o)
  );

  pcim_result #(.BUS_W(BUS_W), .CBE_W(CBE_W)) u_result (
    .clk(clk), .rst(rst), .go_i(go), .capture_i(capture), .finish_i(finish),
    .ad_i(ad_i), .cbe_i(cbe_i),
    .rdata_o(rdata_o), .cbe_stat_o(cbe_stat_o), .valid_o(valid_o), .done_o(done_o)
  );
endmodule

// File: rtl/pcim_checks.sv
module pcim_checks #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned TO_W  = 8,
  parameter int unsigned CBE_W = BUS_W / 8
) (
  input logic             clk,
  input logic             rst,
  input logic             trdy_n_i,
  input logic [BUS_W-1:0] ad_i,
  input logic             frame_n_o,
  input logic             frame_oe_o,
  input logic             irdy_n_o,
  input logic             irdy_oe_o,
  input logic             ad_oe_o,
  input logic             cbe_oe_o,
  input logic [BUS_W-1:0] rdata_o,
  input logic             valid_o,
  input logic             done_o,
  input logic [CBE_W-1:0] cmd_q
);
  localparam int unsigned LIMIT = 2 ** TO_W;

  logic addr_ph, data_ph;
  assign addr_ph = frame_oe_o && !frame_n_o;
  assign data_ph = irdy_oe_o && !irdy_n_o;

  // R2: the address phase keeps IRDY# high and drives AD and C/BE#
  p_addr_phase_r2: assert property (@(posedge clk) disable iff (rst)
    addr_ph |-> (irdy_n_o && ad_oe_o && cbe_oe_o));

  // R3: the address phase is followed directly by the only data phase
  p_single_data_r3: assert property (@(posedge clk) disable iff (rst)
    addr_ph |=> (frame_n_o && data_ph));

  // R4: the AD enable follows the direction bit in the data phase
  p_ad_dir_r4: assert property (@(posedge clk) disable iff (rst)
    data_ph |-> (ad_oe_o == cmd_q[0]));

  // R5: a completed handshake is captured
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (data_ph && !trdy_n_i) |=> (valid_o && rdata_o == $past(ad_i)));

  // R7: done rises only with all drivers released
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !(ad_oe_o || cbe_oe_o || frame_oe_o || irdy_oe_o));

  // R6: the wait never outlasts the watchdog window
  logic [TO_W:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (rst || !data_ph) wait_cnt <= '0;
    else if (wait_cnt != {(TO_W+1){1'b1}}) wait_cnt <= wait_cnt + 1'b1;
  end
  p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= (TO_W+1)'(LIMIT));
endmodule

bind pci_single_master pcim_checks #(.BUS_W(BUS_W), .TO_W(TO_W), .CBE_W(CBE_W)) u_checks (
  .clk(clk), .rst(rst), .trdy_n_i(trdy_n_i), .ad_i(ad_i),
  .frame_n_o(frame_n_o), .frame_oe_o(frame_oe_o),
  .irdy_n_o(irdy_n_o), .irdy_oe_o(irdy_oe_o),
  .ad_oe_o(ad_oe_o), .cbe_oe_o(cbe_oe_o),
  .rdata_o(rdata_o), .valid_o(valid_o), .done_o(done_o), .cmd_q(cmd_q)
);

// File: tb/pci_single_master_tb.sv
`timescale 1ns/1ps
module pci_single_master_tb;
  localparam int TO_W = 4;
  localparam int TO_DONE = 2 ** TO_W + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0, ad_i = '0;
  logic [3:0]  cmd_i = '0, be_i = '0, cbe_i = '0;
  logic        trdy_n_i = 1'b1;
  logic        frame_n_o, frame_oe_o, irdy_n_o, irdy_oe_o, ad_oe_o, cbe_oe_o;
  logic [31:0] ad_o, rdata_o;
  logic [3:0]  cbe_n_o, cbe_stat_o;
  logic        valid_o, done_o;

  int tests = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  pci_single_master #(.BUS_W(32), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .cmd_i(cmd_i), .be_i(be_i), .trdy_n_i(trdy_n_i), .ad_i(ad_i), .cbe_i(cbe_i),
    .frame_n_o(frame_n_o), .frame_oe_o(frame_oe_o), .irdy_n_o(irdy_n_o),
    .irdy_oe_o(irdy_oe_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .cbe_n_o(cbe_n_o),
    .cbe_oe_o(cbe_oe_o), .rdata_o(rdata_o), .cbe_stat_o(cbe_stat_o),
    .valid_o(valid_o), .done_o(done_o)
  );

  // Target model: answers D cycles after it first sees IRDY# low, or never.
  logic        tgt_en = 1'b0;
  int          tgt_dly = 0;
  logic [31:0] tgt_word = 32'h1234_5678;
  logic [3:0]  tgt_cbe = 4'h0;
  int          seen = 0;
  always @(posedge clk) seen <= (irdy_oe_o && !irdy_n_o) ? seen + 1 : 0;
  always @(negedge clk) begin
    if (tgt_en && seen >= 1 + tgt_dly) begin
      trdy_n_i <= 1'b0;
      ad_i     <= tgt_word;
      cbe_i    <= tgt_cbe;
    end else begin
      trdy_n_i <= 1'b1;
      ad_i     <= 32'h0BAD_F00D;
      cbe_i    <= 4'hF;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      finish_run();
    end
  end

  // One access. respond=0 means the target never answers.
  task automatic run_access(input logic [31:0] a, input logic [31:0] w,
                            input logic [3:0] c, input logic [3:0] b,
                            input logic respond, input int dly, input logic poke);
    int first_done = -1;
    logic p_fn = 1'b0, p_in = 1'b0, p_foe = 1'b0, p_ioe = 1'b0, p_aoe = 1'b0, p_coe = 1'b0;
    tgt_en = respond; tgt_dly = dly;
    tgt_word = w ^ 32'h5A5A_A5A5; tgt_cbe = ~b;
    @(negedge clk);
    addr_i = a; wdata_i = w; cmd_i = c; be_i = b; start_i = 1'b1;
    @(posedge clk); // start edge k
    for (int n = 0; n < 60; n++) begin
      @(negedge clk); #1;
      if (n == 0) begin
        start_i = 1'b0;
        addr_i = ~a; wdata_i = ~w; cmd_i = ~c; be_i = ~b; // R9: later changes ignored
        chk(frame_oe_o && !frame_n_o && irdy_oe_o && irdy_n_o, "R2 frame/irdy", {30'd0, frame_n_o, irdy_n_o}, 32'd1);
        chk(ad_oe_o && ad_o == a, "R2 address", ad_o, a);
        chk(cbe_oe_o && cbe_n_o == c, "R2 command", {28'd0, cbe_n_o}, {28'd0, c});
        chk(!done_o && !valid_o, "R8 cleared at start", {30'd0, done_o, valid_o}, 32'd0);
        @(posedge clk); #0.5;
        chk(!frame_n_o && ad_o == a, "R10 no rising-edge change", ad_o, a);
      end else if (n == 1) begin
        chk(frame_oe_o && frame_n_o && irdy_oe_o && !irdy_n_o, "R3 data phase", {30'd0, frame_n_o, irdy_n_o}, 32'd2);
        chk(cbe_oe_o && cbe_n_o == b, "R3 byte enables", {28'd0, cbe_n_o}, {28'd0, b});
        if (c[0]) chk(ad_oe_o && ad_o == w, "R4 write word", ad_o, w);
        else      chk(!ad_oe_o, "R4 read release", {31'd0, ad_oe_o}, 32'd0);
      end
      if (poke && n == 2) begin start_i = 1'b1; addr_i = 32'hFFFF_0000; cmd_i = 4'hB; end
      if (poke && n == 3) start_i = 1'b0;
      if (n >= 2 && done_o && first_done < 0) begin
        first_done = n;
        chk(p_foe && p_ioe && p_fn && p_in && !p_aoe && !p_coe, "R7 end cycle",
            {26'd0, p_foe, p_ioe, p_fn, p_in, p_aoe, p_coe}, 32'h3C);
        chk(!(frame_oe_o || irdy_oe_o || ad_oe_o || cbe_oe_o), "R7 released",
            {28'd0, frame_oe_o, irdy_oe_o, ad_oe_o, cbe_oe_o}, 32'd0);
        break;
      end
      p_fn = frame_n_o; p_in = irdy_n_o; p_foe = frame_oe_o; p_ioe = irdy_oe_o;
      p_aoe = ad_oe_o; p_coe = cbe_oe_o;
    end
    if (respond) begin
      chk(first_done == 4 + dly, "R8 done timing", first_done, 4 + dly);
      chk(valid_o, "R5 valid", {31'd0, valid_o}, 32'd1);
      chk(rdata_o == tgt_word, "R5 read word", rdata_o, tgt_word);
      chk(cbe_stat_o == ~b, "R5 cbe status", {28'd0, cbe_stat_o}, {28'd0, ~b});
    end else begin
      chk(first_done == TO_DONE, "R6 timeout timing", first_done, TO_DONE);
      chk(!valid_o, "R6 invalid after timeout", {31'd0, valid_o}, 32'd0);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(frame_oe_o == 1'b0 && done_o, "R9 no extra access", {30'd0, frame_oe_o, done_o}, 32'd1);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!(frame_oe_o || irdy_oe_o || ad_oe_o || cbe_oe_o), "R1 enables",
        {28'd0, frame_oe_o, irdy_oe_o, ad_oe_o, cbe_oe_o}, 32'd0);
    chk(!done_o && !valid_o, "R1 flags", {30'd0, done_o, valid_o}, 32'd0);
  endtask

  initial begin
    test_reset();
    run_access(32'h0000_0040, 32'hCAFE_0001, 4'b0011, 4'b0000, 1'b1, 0, 1'b0); // I/O write
    run_access(32'h8000_0010, 32'h0,         4'b0110, 4'b1100, 1'b1, 3, 1'b0); // memory read
    run_access(32'h0000_0004, 32'h0,         4'b1010, 4'b0000, 1'b0, 0, 1'b0); // R6 no answer
    run_access(32'h0000_0008, 32'h1111_2222, 4'b1011, 4'b0101, 1'b1, 2, 1'b1); // R9 start while busy
    run_access(32'h0000_00FC, 32'h0,         4'b0010, 4'b1110, 1'b1, 7, 1'b0); // I/O read, long wait
    finish_run();
  end
endmodule